// File: doc/BRIEF.md
# Banked Global Register File

This unit keeps the global integer registers of a processor in eight physical banks of eight 64-bit entries. A 3-bit level value picks the bank that reads and writes see. Software moves between banks by writing a new level. A trap-return also moves between banks: it takes the level from the trap-state entry saved for the current trap level.

Alongside the banks, the unit holds the control state that a trap-return restores: the processor state word, the address-space identifier, the window pointer and the hypervisor state. These come from per-level save arrays, and the trap level then drops by one. The trap-entry logic fills the save arrays through a write port. The "done" and "retry" returns restore state in the same way. The banks are physical, so a level change never copies data. It only moves the read and write selector, and each bank keeps its contents.

Top module: `bgrf_top`

## Requirements
- R1: After reset, every state output (level, trap level, state word, address-space identifier, window pointer, hypervisor state) is zero, and every register index reads zero.
- R2: A write with `wr_en` high and a nonzero index updates that register of the active bank at the clock edge. `rd_data` shows the active bank's register at `rd_idx` combinationally.
- R3: Index 0 always reads zero in every bank, and writes to index 0 are dropped.
- R4: A level write keeps only bits 2:0 of `gl_wr_val`. Each bank keeps its contents across level changes. Rewriting the current level changes nothing visible.
- R5: When a register write and a level change happen in the same cycle, the write goes to the bank that was active before the change.
- R6: A state-word write stores the value with bits 0, 10 and 11 cleared. These three bits of `pstate` are zero at all times.
- R7: A legal trap-return loads `asi` from bits 31:24 of the saved trap-state entry at the current trap level, and `cwp` from bits 7:0. It loads `pstate` from bits 19:8 ANDed with 0xF3F, and then clears bits 0, 10 and 11.
- R8: With hypervisor support enabled (`HV_EN`=1), a legal trap-return loads the level from bits 42:40 of that entry, which changes the active bank. It also loads `hpstate` from the hypervisor save entry at the current trap level.
- R9: A legal trap-return lowers the trap level by one. `tret_done` and `tret_retry` have the same effect, alone or together.
- R10: A trap-return at trap level 0 drives `tret_illegal` high in that cycle and restores nothing.
- R11: In a cycle with a legal trap-return, the trap-return decides the level, state word and trap level, overriding a level, state-word or trap-level write in that cycle. The save arrays take a save write at the clock edge, and a trap-return in the same cycle reads the entry as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_idx | input | 3 | Read register index |
| rd_data | output | 64 | Read data from the active bank |
| wr_en | input | 1 | Register write enable |
| wr_idx | input | 3 | Write register index |
| wr_data | input | 64 | Write data |
| gl_wr_en | input | 1 | Level write command |
| gl_wr_val | input | 64 | Level write value (low 3 bits kept) |
| ps_wr_en | input | 1 | State-word write command |
| ps_wr_val | input | 12 | State-word write value |
| tl_wr_en | input | 1 | Trap-level write command |
| tl_wr_val | input | 3 | Trap-level write value |
| ts_wr_en | input | 1 | Save-array write enable |
| ts_wr_lvl | input | 3 | Save-array entry to write |
| ts_wr_val | input | 64 | Trap-state word to save |
| hts_wr_val | input | 8 | Hypervisor state to save |
| tret_done | input | 1 | Trap-return, done form |
| tret_retry | input | 1 | Trap-return, retry form |
| gl | output | 3 | Current level (active bank) |
| tl | output | 3 | Current trap level |
| pstate | output | 12 | Processor state word |
| asi | output | 8 | Address-space identifier |
| cwp | output | 8 | Window pointer |
| hpstate | output | 8 | Hypervisor state |
| tret_illegal | output | 1 | Trap-return attempted at trap level 0 |

## Verification
A wrong level, or a write steered to the wrong bank, shows up on `rd_data` on the next read of the affected index. The bench reads a random index every cycle, so such a fault appears within a few cycles, or on the first later visit to that bank. A wrong restore field or a wrong trap-level decrement shows on the state outputs one edge after the return. A wrong save entry can stay hidden until a later return reads that level. Heavy random use of save writes and trap-level writes keeps that delay short.

// File: rtl/bgrf_pkg.sv
package bgrf_pkg;
  localparam int XLEN     = 64;
  localparam int NBANK    = 8;
  localparam int NREG     = 8;
  localparam int GL_W     = $clog2(NBANK);
  localparam int IDX_W    = $clog2(NREG);
  localparam int TL_W     = 3;
  localparam int NLVL     = 1 << TL_W;
  localparam int PS_W     = 12;
  localparam int ASI_W    = 8;
  localparam int CWP_W    = 8;
  localparam int HPS_W    = 8;
  localparam int TS_W     = 64;

  // restore field positions inside a saved trap-state word
  localparam int TS_GL_LO  = 40;
  localparam int TS_ASI_LO = 24;
  localparam int TS_PS_LO  = 8;
  localparam int TS_CWP_LO = 0;

  localparam logic [PS_W-1:0] PS_LEGACY_BITS = 12'hC01;
  localparam logic [PS_W-1:0] PS_TRET_KEEP   = 12'hF3F;
endpackage

// File: rtl/bgrf_bank_store.sv
module bgrf_bank_store
  import bgrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GL_W-1:0]  bank_sel,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data
);
  logic [XLEN-1:0] bank_rd [NBANK];
  logic            wr_live;

  assign wr_live = wr_en && (wr_idx != '0);

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic [XLEN-1:0] cells [NREG];
    logic            bank_we;

    assign bank_we = wr_live && (bank_sel == GL_W'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int r = 0; r < NREG; r++) cells[r] <= '0;
      end else if (bank_we) begin
        cells[wr_idx] <= wr_data;
      end
    end

    assign bank_rd[b] = cells[rd_idx];
  end

  assign rd_data = (rd_idx == '0) ? '0 : bank_rd[bank_sel];
endmodule

// File: rtl/bgrf_trap_save.sv
module bgrf_trap_save
  import bgrf_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [TL_W-1:0]  wr_lvl,
  input  logic [TS_W-1:0]  wr_ts,
  input  logic [HPS_W-1:0] wr_hts,
  input  logic [TL_W-1:0]  rd_lvl,
  output logic [TS_W-1:0]  rd_ts,
  output logic [HPS_W-1:0] rd_hts
);
  logic [TS_W-1:0]  ts_mem  [NLVL];
  logic [HPS_W-1:0] hts_mem [NLVL];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NLVL; l++) begin
        ts_mem[l]  <= '0;
        hts_mem[l] <= '0;
      end
    end else if (wr_en) begin
      ts_mem[wr_lvl]  <= wr_ts;
      hts_mem[wr_lvl] <= wr_hts;
    end
  end

  assign rd_ts  = ts_mem[rd_lvl];
  assign rd_hts = hts_mem[rd_lvl];
endmodule

// File: rtl/bgrf_ctrl.sv
module bgrf_ctrl
  import bgrf_pkg::*;
#(
  parameter bit HV_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gl_wr_en,
  input  logic [GL_W-1:0]  gl_wr_lo,
  input  logic             ps_wr_en,
  input  logic [PS_W-1:0]  ps_wr_val,
  input  logic             tl_wr_en,
  input  logic [TL_W-1:0]  tl_wr_val,
  input  logic             tret_req,
  input  logic [TS_W-1:0]  saved_ts,
  input  logic [HPS_W-1:0] saved_hts,
  output logic [GL_W-1:0]  gl_q,
  output logic [TL_W-1:0]  tl_q,
  output logic [PS_W-1:0]  ps_q,
  output logic [ASI_W-1:0] asi_q,
  output logic [CWP_W-1:0] cwp_q,
  output logic [HPS_W-1:0] hps_q,
  output logic             tret_bad
);
  logic [GL_W-1:0]  gl_d;
  logic [TL_W-1:0]  tl_d;
  logic [PS_W-1:0]  ps_d;
  logic [ASI_W-1:0] asi_d;
  logic [CWP_W-1:0] cwp_d;
  logic [HPS_W-1:0] hps_d;
  logic             tret_go;

  assign tret_bad = tret_req && (tl_q == '0);
  assign tret_go  = tret_req && (tl_q != '0);

  always_comb begin
    gl_d  = gl_q;
    tl_d  = tl_q;
    ps_d  = ps_q;
    asi_d = asi_q;
    cwp_d = cwp_q;
    hps_d = hps_q;
    if (gl_wr_en) gl_d = gl_wr_lo;
    if (ps_wr_en) ps_d = ps_wr_val & ~PS_LEGACY_BITS;
    if (tl_wr_en) tl_d = tl_wr_val;
    if (tret_go) begin
      asi_d = saved_ts[TS_ASI_LO +: ASI_W];
      cwp_d = saved_ts[TS_CWP_LO +: CWP_W];
      ps_d  = saved_ts[TS_PS_LO +: PS_W] & PS_TRET_KEEP & ~PS_LEGACY_BITS;
      tl_d  = tl_q - 1'b1;
      if (HV_EN) begin
        gl_d  = saved_ts[TS_GL_LO +: GL_W];
        hps_d = saved_hts;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gl_q  <= '0;
      tl_q  <= '0;
      ps_q  <= '0;
      asi_q <= '0;
      cwp_q <= '0;
      hps_q <= '0;
    end else begin
      gl_q  <= gl_d;
      tl_q  <= tl_d;
      ps_q  <= ps_d;
      asi_q <= asi_d;
      cwp_q <= cwp_d;
      hps_q <= hps_d;
    end
  end
endmodule

// File: rtl/bgrf_top.sv
module bgrf_top
  import bgrf_pkg::*;
#(
  parameter bit HV_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [XLEN-1:0]  rd_data,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [XLEN-1:0]  wr_data,
  input  logic             gl_wr_en,
  input  logic [XLEN-1:0]  gl_wr_val,
  input  logic             ps_wr_en,
  input  logic [PS_W-1:0]  ps_wr_val,
  input  logic             tl_wr_en,
  input  logic [TL_W-1:0]  tl_wr_val,
  input  logic             ts_wr_en,
  input  logic [TL_W-1:0]  ts_wr_lvl,
  input  logic [TS_W-1:0]  ts_wr_val,
  input  logic [HPS_W-1:0] hts_wr_val,
  input  logic             tret_done,
  input  logic             tret_retry,
  output logic [GL_W-1:0]  gl,
  output logic [TL_W-1:0]  tl,
  output logic [PS_W-1:0]  pstate,
  output logic [ASI_W-1:0] asi,
  output logic [CWP_W-1:0] cwp,
  output logic [HPS_W-1:0] hpstate,
  output logic             tret_illegal
);
  logic [TS_W-1:0]  ts_entry;
  logic [HPS_W-1:0] hts_entry;
  logic             tret_req;

  assign tret_req = tret_done | tret_retry;

  bgrf_bank_store u_banks (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_sel (gl),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  bgrf_trap_save u_save (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (ts_wr_en),
    .wr_lvl (ts_wr_lvl),
    .wr_ts  (ts_wr_val),
    .wr_hts (hts_wr_val),
    .rd_lvl (tl),
    .rd_ts  (ts_entry),
    .rd_hts (hts_entry)
  );

  bgrf_ctrl #(.HV_EN(HV_EN)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .gl_wr_en  (gl_wr_en),
    .gl_wr_lo  (gl_wr_val[GL_W-1:0]),
    .ps_wr_en  (ps_wr_en),
    .ps_wr_val (ps_wr_val),
    .tl_wr_en  (tl_wr_en),
    .tl_wr_val (tl_wr_val),
    .tret_req  (tret_req),
    .saved_ts  (ts_entry),
    .saved_hts (hts_entry),
    .gl_q      (gl),
    .tl_q      (tl),
    .ps_q      (pstate),
    .asi_q     (asi),
    .cwp_q     (cwp),
    .hps_q     (hpstate),
    .tret_bad  (tret_illegal)
  );
endmodule

// File: rtl/bgrf_chk.sv
module bgrf_chk
  import bgrf_pkg::*;
#(
  parameter bit HV_EN = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic [IDX_W-1:0] rd_idx,
  input logic [XLEN-1:0]  rd_data,
  input logic             gl_wr_en,
  input logic [XLEN-1:0]  gl_wr_val,
  input logic             ps_wr_en,
  input logic             tl_wr_en,
  input logic             tret_done,
  input logic             tret_retry,
  input logic [TS_W-1:0]  ts_entry,
  input logic [HPS_W-1:0] hts_entry,
  input logic [GL_W-1:0]  gl,
  input logic [TL_W-1:0]  tl,
  input logic [PS_W-1:0]  pstate,
  input logic [ASI_W-1:0] asi,
  input logic [CWP_W-1:0] cwp,
  input logic [HPS_W-1:0] hpstate,
  input logic             tret_illegal
);
  logic tret_any;
  assign tret_any = tret_done | tret_retry;

  // R3
  zero_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_idx == '0) |-> (rd_data == '0));

  // R4
  gl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (gl_wr_en && !tret_any) |=> (gl == $past(gl_wr_val[GL_W-1:0])));

  // R6
  legacy_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate & PS_LEGACY_BITS) == '0);

  // R7
  restore_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tret_any && tl != '0) |=> (asi == $past(ts_entry[TS_ASI_LO +: ASI_W]))
                              && (cwp == $past(ts_entry[TS_CWP_LO +: CWP_W])));

  // R8
  restore_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (HV_EN && tret_any && tl != '0) |=> (gl == $past(ts_entry[TS_GL_LO +: GL_W]))
                                       && (hpstate == $past(hts_entry)));

  // R9
  tl_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tret_any && tl != '0) |=> (tl == $past(tl) - 1'b1));

  // R10
  illegal_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tret_any && tl == '0) |-> tret_illegal);

  // R10
  illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tret_any && tl == '0 && !gl_wr_en && !ps_wr_en && !tl_wr_en)
      |=> ($stable(tl) && $stable(gl) && $stable(pstate) && $stable(asi)
           && $stable(cwp) && $stable(hpstate)));
endmodule

bind bgrf_top bgrf_chk #(.HV_EN(HV_EN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .rd_idx       (rd_idx),
  .rd_data      (rd_data),
  .gl_wr_en     (gl_wr_en),
  .gl_wr_val    (gl_wr_val),
  .ps_wr_en     (ps_wr_en),
  .tl_wr_en     (tl_wr_en),
  .tret_done    (tret_done),
  .tret_retry   (tret_retry),
  .ts_entry     (ts_entry),
  .hts_entry    (hts_entry),
  .gl           (gl),
  .tl           (tl),
  .pstate       (pstate),
  .asi          (asi),
  .cwp          (cwp),
  .hpstate      (hpstate),
  .tret_illegal (tret_illegal)
);

// File: tb/tb_bgrf_top.sv
`timescale 1ns/1ps
module tb_bgrf_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  rd_idx, wr_idx, tl_wr_val, ts_wr_lvl;
  logic [63:0] rd_data, wr_data, gl_wr_val, ts_wr_val;
  logic        wr_en, gl_wr_en, ps_wr_en, tl_wr_en, ts_wr_en, tret_done, tret_retry;
  logic [11:0] ps_wr_val, pstate;
  logic [7:0]  hts_wr_val, asi, cwp, hpstate;
  logic [2:0]  gl, tl;
  logic        tret_illegal;

  always #5 clk = ~clk;

  bgrf_top dut (.*);

  int checks = 0, fails = 0;
  bit finished = 1'b0;

  logic [63:0] m_reg [8][8];
  logic [63:0] m_ts [8];
  logic [7:0]  m_hts [8];
  logic [2:0]  m_gl, m_tl;
  logic [11:0] m_ps;
  logic [7:0]  m_asi, m_cwp, m_hps;

  function automatic logic [63:0] exp_rd(input logic [2:0] idx);
    return (idx == 3'd0) ? 64'd0 : m_reg[m_gl][idx];
  endfunction

  function automatic logic [11:0] tret_ps(input logic [63:0] ts);
    return ts[19:8] & 12'hF3F & ~12'hC01;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle_in();
    wr_en = 0; wr_idx = 0; wr_data = 0; gl_wr_en = 0; gl_wr_val = 0;
    ps_wr_en = 0; ps_wr_val = 0; tl_wr_en = 0; tl_wr_val = 0;
    ts_wr_en = 0; ts_wr_lvl = 0; ts_wr_val = 0; hts_wr_val = 0;
    tret_done = 0; tret_retry = 0; rd_idx = 0;
  endtask

  task automatic model_edge();
    logic [2:0] ogl = m_gl, otl = m_tl;
    logic [63:0] ots = m_ts[m_tl];
    logic [7:0]  ohts = m_hts[m_tl];
    bit go = (tret_done || tret_retry) && (otl != 0);
    if (wr_en && wr_idx != 0) m_reg[ogl][wr_idx] = wr_data;
    if (ts_wr_en) begin m_ts[ts_wr_lvl] = ts_wr_val; m_hts[ts_wr_lvl] = hts_wr_val; end
    if (gl_wr_en) m_gl = gl_wr_val[2:0];
    if (ps_wr_en) m_ps = ps_wr_val & ~12'hC01;
    if (tl_wr_en) m_tl = tl_wr_val;
    if (go) begin
      m_asi = ots[31:24]; m_cwp = ots[7:0]; m_ps = tret_ps(ots);
      m_gl = ots[42:40]; m_hps = ohts; m_tl = otl - 3'd1;
    end
  endtask

  // inputs already driven after a falling edge
  task automatic cycle();
    logic [63:0] er;
    #1;
    er = exp_rd(rd_idx);
    chk(rd_data === er, (rd_idx == 0) ? "R3" : "R2", rd_data, er);
    chk(tret_illegal === ((tret_done || tret_retry) && m_tl == 0), "R10", 64'(tret_illegal), 64'(m_tl == 0));
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(gl === m_gl, "R4 R8", 64'(gl), 64'(m_gl));
    chk(tl === m_tl, "R9", 64'(tl), 64'(m_tl));
    chk(pstate === m_ps, "R6 R7", 64'(pstate), 64'(m_ps));
    chk(asi === m_asi && cwp === m_cwp, "R7", {asi, cwp}, {m_asi, m_cwp});
    chk(hpstate === m_hps, "R8", 64'(hpstate), 64'(m_hps));
    idle_in();
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    idle_in();
    rst_n = 0;
    for (int b = 0; b < 8; b++) begin
      m_ts[b] = 0; m_hts[b] = 0;
      for (int r = 0; r < 8; r++) m_reg[b][r] = 0;
    end
    m_gl = 0; m_tl = 0; m_ps = 0; m_asi = 0; m_cwp = 0; m_hps = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk({gl, tl, pstate, asi, cwp, hpstate} === '0, "R1", 64'({gl, tl, pstate, asi, cwp, hpstate}), 64'd0);
    for (int i = 0; i < 8; i++) begin
      rd_idx = 3'(i); #1;
      chk(rd_data === 64'd0, "R1", rd_data, 64'd0);
    end
    @(negedge clk);

    // R3 write to index 0 dropped
    wr_en = 1; wr_idx = 0; wr_data = 64'hDEAD; cycle();
    rd_idx = 0; cycle();
    // R2 write then read bank 0
    wr_en = 1; wr_idx = 5; wr_data = 64'h1111_2222_3333_4444; cycle();
    // R5 write with level change lands in old bank 0
    wr_en = 1; wr_idx = 6; wr_data = 64'hAAAA; gl_wr_en = 1; gl_wr_val = 64'hFFFF_FFF3; cycle();
    rd_idx = 6; cycle();
    chk(rd_data === 64'd0, "R5", rd_data, 64'd0);
    gl_wr_en = 1; gl_wr_val = 0; rd_idx = 6; cycle();
    rd_idx = 6; #1; chk(rd_data === 64'hAAAA, "R5", rd_data, 64'hAAAA); @(negedge clk);
    // R4 same-level write no visible change
    gl_wr_en = 1; gl_wr_val = 64'h8; rd_idx = 5; cycle();
    rd_idx = 5; #1; chk(rd_data === 64'h1111_2222_3333_4444, "R4", rd_data, 64'h1111_2222_3333_4444); @(negedge clk);
    // R6 legacy bits cleared
    ps_wr_en = 1; ps_wr_val = 12'hFFF; cycle();
    // R10 illegal return at TL 0
    tret_done = 1; cycle();
    // R11 save write and return priority
    ts_wr_en = 1; ts_wr_lvl = 2; ts_wr_val = 64'h0000_0500_AB12_3456; hts_wr_val = 8'h5A;
    tl_wr_en = 1; tl_wr_val = 2; cycle();
    tret_retry = 1; gl_wr_en = 1; gl_wr_val = 1; ps_wr_en = 1; ps_wr_val = 12'h002;
    tl_wr_en = 1; tl_wr_val = 7; cycle();
    chk(tl === 3'd1 && gl === 3'd5, "R11", 64'({gl, tl}), 64'({3'd5, 3'd1}));
    // R9 both returns together act once
    tl_wr_en = 1; tl_wr_val = 3; cycle();
    tret_done = 1; tret_retry = 1; cycle();
    chk(tl === 3'd2, "R9", 64'(tl), 64'd2);

    for (int n = 0; n < 3000; n++) begin
      rd_idx = 3'($urandom);
      wr_en = ($urandom % 2) == 0; wr_idx = 3'($urandom); wr_data = {$urandom, $urandom};
      gl_wr_en = ($urandom % 5) == 0; gl_wr_val = {$urandom, $urandom};
      ps_wr_en = ($urandom % 7) == 0; ps_wr_val = 12'($urandom);
      tl_wr_en = ($urandom % 6) == 0; tl_wr_val = 3'($urandom);
      ts_wr_en = ($urandom % 3) == 0; ts_wr_lvl = 3'($urandom);
      ts_wr_val = {$urandom, $urandom}; hts_wr_val = 8'($urandom);
      tret_done = ($urandom % 8) == 0; tret_retry = ($urandom % 9) == 0;
      cycle();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule